// File: doc/BRIEF.md
# Torus Dimension-Order Router

This block is one node of a two-dimensional torus network that connects small processor tiles. Every ring in the torus is unidirectional. The node therefore has one incoming and one outgoing link for X, one of each for Y, an injection port from the local tile and an ejection port back to it. Each inter-router link carries two virtual channels over a single shared flit bus, with a valid and a ready wire for each channel. Only one flit crosses a physical link in any cycle.

A packet is a run of flits on one virtual channel, and its last flit has the tail bit set. The first flit carries the destination coordinates. The node compares them with its own coordinates (`my_x_i`, `my_y_i`) and makes one fixed choice: it moves along X until X matches, then along Y, and then ejects the packet locally.

Virtual channels break the ring cycles. Every packet starts a ring on channel 0. It moves to channel 1 when it takes the wraparound edge of that ring, which is the hop leaving the node whose coordinate is the ring maximum. It drops back to channel 0 when it turns from X into Y. Each input channel has a small FIFO. Each output port arbitrates round-robin. An output channel that a header wins stays locked to that packet until its tail flit passes. Nothing is ever dropped: a full FIFO deasserts ready toward the upstream node.

Top module: `tdr_router`

## Requirements
- R1: A header whose destination X (flit bits [11:10]) differs from `my_x_i` leaves on the X output.
- R2: A header whose destination X equals `my_x_i` and whose destination Y (bits [9:8]) differs from `my_y_i` leaves on the Y output.
- R3: A header whose destination X and Y both equal the node coordinates leaves on the ejection port.
- R4: The output virtual channel (0 or 1) is chosen as follows:
  - Injected flits start on channel 0.
  - On X, the channel is 1 if the flit arrived on X channel 1, or if `my_x_i` equals K-1.
  - On Y, the channel is 1 if the flit arrived on Y channel 1, or if `my_y_i` equals K-1.
  - Otherwise the channel is 0. A turn from X into Y therefore restarts on channel 0.
- R5: The flits that follow a header (tail is bit 12, set on the last flit) take the header's output channel. That output channel serves no other input until the tail has left.
- R6: When several inputs compete for one output port, grants rotate round-robin, starting after the most recent winner.
- R7: A flit is offered only on an output channel whose ready is high. While ready is low the flit waits in its input FIFO. An input channel's ready drops once its FIFO holds DEPTH flits. No flit is lost.
- R8: Different output ports move flits in the same cycle. Each port presents at most one flit per cycle.
- R9: After reset every output valid is low and every input ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| my_x_i | input | 2 | X coordinate of this node |
| my_y_i | input | 2 | Y coordinate of this node |
| x_in_valid_i | input | 2 | Incoming X link, valid per virtual channel |
| x_in_ready_o | output | 2 | Incoming X link, ready per virtual channel |
| x_in_flit_i | input | 13 | Incoming X link flit |
| y_in_valid_i | input | 2 | Incoming Y link, valid per virtual channel |
| y_in_ready_o | output | 2 | Incoming Y link, ready per virtual channel |
| y_in_flit_i | input | 13 | Incoming Y link flit |
| loc_in_valid_i | input | 1 | Injection valid |
| loc_in_ready_o | output | 1 | Injection ready |
| loc_in_flit_i | input | 13 | Injection flit |
| x_out_valid_o | output | 2 | Outgoing X link, valid per virtual channel |
| x_out_ready_i | input | 2 | Outgoing X link, ready per virtual channel |
| x_out_flit_o | output | 13 | Outgoing X link flit |
| y_out_valid_o | output | 2 | Outgoing Y link, valid per virtual channel |
| y_out_ready_i | input | 2 | Outgoing Y link, ready per virtual channel |
| y_out_flit_o | output | 13 | Outgoing Y link flit |
| ej_valid_o | output | 1 | Ejection valid |
| ej_ready_i | input | 1 | Ejection ready |
| ej_flit_o | output | 13 | Ejection flit |

## Verification
Two events can fall in the same cycle on one output port: a locked packet's tail releasing its channel, and a waiting header from another input trying to claim a channel on the same port. The bench provokes this by queueing a two-flit packet and a competing one-flit packet behind a deasserted ready, then opening the port. It checks the order of departure flit by flit: the locked body must go first, even though round-robin alone would favour the other input, and the waiting header must leave on the very next cycle. A separate test queues packets on two virtual channels of one port and judges that the grants alternate between them.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  typedef enum logic [1:0] {
    PORT_X = 2'd0,
    PORT_Y = 2'd1,
    PORT_L = 2'd2
  } port_e;

  typedef struct packed {
    port_e port;
    logic  vc;
  } route_t;
endpackage

// File: rtl/tdr_route.sv
module tdr_route
  import tdr_pkg::*;
#(
  parameter int K  = 4,
  parameter int CW = $clog2(K)
) (
  input  logic [CW-1:0] my_x_i,
  input  logic [CW-1:0] my_y_i,
  input  logic [CW-1:0] dst_x_i,
  input  logic [CW-1:0] dst_y_i,
  input  port_e         src_port_i,
  input  logic          src_vc_i,
  output route_t        route_o
);
  localparam logic [CW-1:0] EDGE = CW'(K - 1);

  always_comb begin
    route_o = '{port: PORT_L, vc: 1'b0};
    if (dst_x_i != my_x_i) begin
      route_o.port = PORT_X;
      // keep ring channel, switch to 1 at the dateline hop
      route_o.vc   = (src_port_i == PORT_X && src_vc_i) || (my_x_i == EDGE);
    end else if (dst_y_i != my_y_i) begin
      route_o.port = PORT_Y;
      route_o.vc   = (src_port_i == PORT_Y && src_vc_i) || (my_y_i == EDGE);
    end
  end
endmodule

// File: rtl/tdr_vc_fifo.sv
module tdr_vc_fifo #(
  parameter int W     = 13,
  parameter int DEPTH = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [AW-1:0] wp_q, rp_q;
  logic [NW-1:0] cnt_q;

  assign full_o  = (cnt_q == NW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign dout_o  = mem_q[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      mem_q <= '0;
    end else begin
      if (push_i) begin
        mem_q[wp_q] <= din_i;
        wp_q        <= nxt(wp_q);
      end
      if (pop_i) rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + NW'(push_i) - NW'(pop_i);
    end
  end

  p_pop_nonempty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/tdr_out_arb.sv
module tdr_out_arb #(
  parameter int NI  = 6,
  localparam int IW = $clog2(NI)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NI-1:0] req_i,
  input  logic [NI-1:0] req_vc_i,
  input  logic [NI-1:0] req_tail_i,
  input  logic [1:0]    vc_ready_i,
  output logic [NI-1:0] gnt_o,
  output logic [IW-1:0] win_o,
  output logic [1:0]    valid_o
);
  logic [1:0]         busy_q;
  logic [1:0][IW-1:0] owner_q;
  logic [IW-1:0]      ptr_q;
  logic [NI-1:0]      elig;
  logic               found;
  logic               wvc;

  for (genvar i = 0; i < NI; i++) begin : g_elig
    assign elig[i] = req_i[i] && vc_ready_i[req_vc_i[i]] &&
                     (!busy_q[req_vc_i[i]] || owner_q[req_vc_i[i]] == IW'(i));
  end

  always_comb begin
    found = 1'b0;
    win_o = '0;
    for (int k = 0; k < NI; k++) begin
      int j;
      j = int'(ptr_q) + k;
      if (j >= NI) j = j - NI;
      if (!found && elig[j]) begin
        found = 1'b1;
        win_o = IW'(j);
      end
    end
  end

  assign wvc     = req_vc_i[win_o];
  assign gnt_o   = found ? (NI'(1) << win_o) : '0;
  assign valid_o = found ? (2'b01 << wvc) : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= '0;
      owner_q <= '0;
      ptr_q   <= '0;
    end else if (found) begin
      ptr_q        <= (win_o == IW'(NI - 1)) ? '0 : win_o + 1'b1;
      busy_q[wvc]  <= !req_tail_i[win_o];
      owner_q[wvc] <= win_o;
    end
  end

  p_lock_owner_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found && busy_q[wvc]) |-> (win_o == owner_q[wvc]));
endmodule

// File: rtl/tdr_router.sv
module tdr_router
  import tdr_pkg::*;
#(
  parameter int K     = 4,
  parameter int PW    = 8,
  parameter int DEPTH = 2,
  localparam int CW   = $clog2(K),
  localparam int FW   = 1 + 2 * CW + PW,
  localparam int NC   = 6,
  localparam int NP   = 3,
  localparam int IW   = $clog2(NC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] my_x_i,
  input  logic [CW-1:0] my_y_i,
  input  logic [1:0]    x_in_valid_i,
  output logic [1:0]    x_in_ready_o,
  input  logic [FW-1:0] x_in_flit_i,
  input  logic [1:0]    y_in_valid_i,
  output logic [1:0]    y_in_ready_o,
  input  logic [FW-1:0] y_in_flit_i,
  input  logic          loc_in_valid_i,
  output logic          loc_in_ready_o,
  input  logic [FW-1:0] loc_in_flit_i,
  output logic [1:0]    x_out_valid_o,
  input  logic [1:0]    x_out_ready_i,
  output logic [FW-1:0] x_out_flit_o,
  output logic [1:0]    y_out_valid_o,
  input  logic [1:0]    y_out_ready_i,
  output logic [FW-1:0] y_out_flit_o,
  output logic          ej_valid_o,
  input  logic          ej_ready_i,
  output logic [FW-1:0] ej_flit_o
);
  // channel index: 0/1 X vc0/vc1, 2/3 Y vc0/vc1, 4 injection, 5 unused
  logic [NC-1:0]          in_vld, full, empty, pop, tail, rvc;
  logic [NC-1:0][FW-1:0]  head;
  route_t                 rt [NC];
  logic [NP-1:0][NC-1:0]  req, gnt;
  logic [NP-1:0][IW-1:0]  win;
  logic [NP-1:0][1:0]     vrdy, ovld;

  assign in_vld = {1'b0, loc_in_valid_i, y_in_valid_i, x_in_valid_i};

  for (genvar c = 0; c < NC; c++) begin : g_ch
    logic [FW-1:0] din;
    route_t        rt_new, rt_q;
    logic          in_pkt_q;

    assign din = (c < 2) ? x_in_flit_i : (c < 4) ? y_in_flit_i : loc_in_flit_i;

    tdr_vc_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
      .clk_i, .rst_ni,
      .push_i (in_vld[c] && !full[c]),
      .din_i  (din),
      .pop_i  (pop[c]),
      .dout_o (head[c]),
      .full_o (full[c]),
      .empty_o(empty[c])
    );

    tdr_route #(.K(K), .CW(CW)) u_route (
      .my_x_i, .my_y_i,
      .dst_x_i   (head[c][FW-2 -: CW]),
      .dst_y_i   (head[c][FW-2-CW -: CW]),
      .src_port_i(port_e'(2'(c / 2))),
      .src_vc_i  (1'(c % 2)),
      .route_o   (rt_new)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_pkt_q <= 1'b0;
        rt_q     <= '{port: PORT_L, vc: 1'b0};
      end else if (pop[c]) begin
        in_pkt_q <= !head[c][FW-1];
        if (!in_pkt_q) rt_q <= rt_new;
      end
    end

    assign rt[c]   = in_pkt_q ? rt_q : rt_new;
    assign tail[c] = head[c][FW-1];
    assign rvc[c]  = rt[c].vc;
  end

  always_comb begin
    pop = '0;
    for (int c = 0; c < NC; c++) begin
      for (int p = 0; p < NP; p++) begin
        req[p][c] = !empty[c] && (rt[c].port == port_e'(p));
        pop[c]    = pop[c] | gnt[p][c];
      end
    end
  end

  assign vrdy = {{1'b0, ej_ready_i}, y_out_ready_i, x_out_ready_i};

  for (genvar p = 0; p < NP; p++) begin : g_port
    tdr_out_arb #(.NI(NC)) u_arb (
      .clk_i, .rst_ni,
      .req_i     (req[p]),
      .req_vc_i  (rvc),
      .req_tail_i(tail),
      .vc_ready_i(vrdy[p]),
      .gnt_o     (gnt[p]),
      .win_o     (win[p]),
      .valid_o   (ovld[p])
    );
  end

  assign x_out_valid_o  = ovld[0];
  assign y_out_valid_o  = ovld[1];
  assign ej_valid_o     = ovld[2][0];
  assign x_out_flit_o   = head[win[0]];
  assign y_out_flit_o   = head[win[1]];
  assign ej_flit_o      = head[win[2]];
  assign x_in_ready_o   = ~full[1:0];
  assign y_in_ready_o   = ~full[3:2];
  assign loc_in_ready_o = ~full[4];

  p_valid_needs_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((x_out_valid_o & ~x_out_ready_i) == 2'b00) &&
    ((y_out_valid_o & ~y_out_ready_i) == 2'b00) && !(ej_valid_o && !ej_ready_i));
  p_x_dateline_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_out_valid_o[0] |-> (my_x_i != CW'(K - 1)));
  p_y_dateline_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_out_valid_o[0] |-> (my_y_i != CW'(K - 1)));
endmodule

// File: tb/tdr_router_test.sv
module tdr_router_test;
  localparam int FW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] my_x = '0, my_y = '0;
  logic [1:0] x_iv = '0, y_iv = '0, x_ir, y_ir;
  logic [FW-1:0] x_if = '0, y_if = '0, l_if = '0;
  logic l_iv = 1'b0, l_ir;
  logic [1:0] x_ov, y_ov, x_ordy = 2'b11, y_ordy = 2'b11;
  logic [FW-1:0] x_of, y_of, e_of;
  logic e_ov, e_rdy = 1'b1;

  tdr_router uut (
    .clk_i(clk), .rst_ni(rst_n), .my_x_i(my_x), .my_y_i(my_y),
    .x_in_valid_i(x_iv), .x_in_ready_o(x_ir), .x_in_flit_i(x_if),
    .y_in_valid_i(y_iv), .y_in_ready_o(y_ir), .y_in_flit_i(y_if),
    .loc_in_valid_i(l_iv), .loc_in_ready_o(l_ir), .loc_in_flit_i(l_if),
    .x_out_valid_o(x_ov), .x_out_ready_i(x_ordy), .x_out_flit_o(x_of),
    .y_out_valid_o(y_ov), .y_out_ready_i(y_ordy), .y_out_flit_o(y_of),
    .ej_valid_o(e_ov), .ej_ready_i(e_rdy), .ej_flit_o(e_of)
  );

  int checks = 0, fails = 0;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk(input logic t, input logic [1:0] dx,
                                       input logic [1:0] dy, input logic [7:0] pl);
    return {t, dx, dy, pl};
  endfunction

  // {my_x, my_y, in_port(0 X,1 Y,2 L), in_vc, dst_x, dst_y, expected {ej,y1,y0,x1,x0}}
  localparam logic [15:0] VEC [10] = '{
    {2'd1, 2'd1, 2'd2, 1'b0, 2'd3, 2'd0, 5'b00001},
    {2'd3, 2'd1, 2'd2, 1'b0, 2'd0, 2'd1, 5'b00010},
    {2'd1, 2'd1, 2'd0, 1'b1, 2'd3, 2'd0, 5'b00010},
    {2'd2, 2'd2, 2'd0, 1'b1, 2'd2, 2'd0, 5'b00100},
    {2'd2, 2'd3, 2'd0, 1'b0, 2'd2, 2'd1, 5'b01000},
    {2'd2, 2'd1, 2'd1, 1'b1, 2'd2, 2'd3, 5'b01000},
    {2'd0, 2'd0, 2'd1, 1'b0, 2'd0, 2'd0, 5'b10000},
    {2'd2, 2'd1, 2'd2, 1'b0, 2'd2, 2'd1, 5'b10000},
    {2'd0, 2'd2, 2'd1, 1'b0, 2'd0, 2'd3, 5'b00100},
    {2'd3, 2'd0, 2'd0, 1'b0, 2'd1, 2'd0, 5'b00010}
  };

  function automatic logic [4:0] ovec();
    return {e_ov, y_ov, x_ov};
  endfunction

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out valid", 16'(ovec()), 16'h0);
    check("R9 in ready", 16'({x_ir, y_ir, l_ir}), 16'h1f);

    // R5/R7: lock survives competition; hold while ready low
    my_x = 2'd1; my_y = 2'd1; x_ordy = 2'b00;
    x_iv = 2'b01; x_if = mk(1'b0, 2'd3, 2'd0, 8'h11);
    l_iv = 1'b1;  l_if = mk(1'b1, 2'd3, 2'd0, 8'h21);
    @(negedge clk);
    l_iv = 1'b0; x_if = mk(1'b1, 2'd3, 2'd0, 8'h12);
    @(negedge clk);
    x_iv = 2'b00;
    check("R7 x vc0 full ready", 16'(x_ir[0]), 16'h0);
    check("R7 held no valid", 16'(x_ov), 16'h0);
    x_ordy = 2'b11;
    #1;
    check("R5 first head", 16'({x_ov, x_of}), 16'({2'b01, mk(1'b0, 2'd3, 2'd0, 8'h11)}));
    @(negedge clk);
    check("R5 locked body", 16'({x_ov, x_of}), 16'({2'b01, mk(1'b1, 2'd3, 2'd0, 8'h12)}));
    @(negedge clk);
    check("R5 handover", 16'({x_ov, x_of}), 16'({2'b01, mk(1'b1, 2'd3, 2'd0, 8'h21)}));
    @(negedge clk);
    check("R7 drained", 16'({x_ov, x_ir}), 16'({2'b00, 2'b11}));

    // R6: X vc1 input and injection alternate on X port
    x_ordy = 2'b00;
    x_iv = 2'b10; x_if = mk(1'b1, 2'd3, 2'd0, 8'h31);
    l_iv = 1'b1;  l_if = mk(1'b1, 2'd3, 2'd0, 8'h41);
    @(negedge clk);
    x_if = mk(1'b1, 2'd3, 2'd0, 8'h32);
    l_if = mk(1'b1, 2'd3, 2'd0, 8'h42);
    @(negedge clk);
    x_iv = 2'b00; l_iv = 1'b0;
    x_ordy = 2'b11;
    #1;
    check("R6 grant1", 16'({x_ov, x_of[7:0]}), 16'({2'b10, 8'h31}));
    @(negedge clk);
    check("R6 grant2", 16'({x_ov, x_of[7:0]}), 16'({2'b01, 8'h41}));
    @(negedge clk);
    check("R6 grant3", 16'({x_ov, x_of[7:0]}), 16'({2'b10, 8'h32}));
    @(negedge clk);
    check("R6 grant4", 16'({x_ov, x_of[7:0]}), 16'({2'b01, 8'h42}));
    @(negedge clk);

    // R8: ejection and X transfer in the same cycle
    x_iv = 2'b01; x_if = mk(1'b1, 2'd3, 2'd2, 8'h51);
    l_iv = 1'b1;  l_if = mk(1'b1, 2'd1, 2'd1, 8'h52);
    @(negedge clk);
    x_iv = 2'b00; l_iv = 1'b0;
    check("R8 parallel valids", 16'(ovec()), 16'b10001);
    check("R8 parallel data", {x_of[7:0], e_of[7:0]}, 16'h5152);
    @(negedge clk);
    check("R8 both gone", 16'(ovec()), 16'h0);

    // R1-R4 vector walk
    for (int i = 0; i < 10; i++) begin
      logic [15:0] v;
      logic [FW-1:0] f, got;
      v = VEC[i];
      my_x = v[15:14]; my_y = v[13:12];
      f = mk(1'b1, v[8:7], v[6:5], 8'(i));
      case (v[11:10])
        2'd0: begin x_iv = 2'b01 << v[9]; x_if = f; end
        2'd1: begin y_iv = 2'b01 << v[9]; y_if = f; end
        default: begin l_iv = 1'b1; l_if = f; end
      endcase
      @(negedge clk);
      x_iv = '0; y_iv = '0; l_iv = 1'b0;
      got = v[4] ? e_of : (|v[3:2]) ? y_of : x_of;
      check("R1 R2 R3 R4 route/vc", 16'(ovec()), 16'(v[4:0]));
      check("R1 R2 R3 flit data", 16'(got), 16'(f));
      @(negedge clk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule